// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block is a sequential engine that walks a singly linked chain of 32-bit capability headers held in a 4 KB configuration memory. It reaches that memory through one synchronous single-port RAM port of 32-bit words, with read data returned one cycle after the request. Each header packs three fields. The 16-bit ID sits in bits 15:0. The 4-bit version sits in bits 19:16. The 12-bit byte offset of the following header sits in bits 31:20, where 0 ends the chain. The walk always begins at byte offset 0x100, the first word past the 256-byte legacy region.

A start strobe launches one of three operations:

- A lookup returns the offset of the header with the requested ID, together with the offset of the header before it.
- A tail search ignores the ID and returns the last header of the chain.
- An append walks to the tail, patches the tail's next field to point at a new offset, and writes a fresh header at that offset with a next field of 0. When the new offset is 0x100 itself, the append writes the header directly.

Malformed pointers, runaway chains and impossible append requests raise an error flag instead of touching memory or hanging. The start, busy and done pins are plain control strobes. There is no streaming data interface, so no back-pressure applies. A start is accepted only while busy is low, and the results hold from done until the next accepted start.

Top module: `xcw_walker`

## Requirements
- R1: In lookup mode (op code 0, and op code 3, which acts the same), the walk visits headers from 0x100 along the next field (bits 31:20) and compares each ID (bits 15:0). It stops at the first header whose ID equals cap_id and returns that header's offset on found_off. It returns the offset of the header visited before it on prev_off, or 0 when the match is the first header.
- R2: When a lookup reaches a header whose next field is 0 without a match, found_off is 0 and prev_off is that last header's offset, with err low.
- R3: A header at 0x100 whose 32 bits are all zero denotes an empty chain: a lookup returns found_off 0 and prev_off 0 with err low.
- R4: Tail search (op code 1) never matches on ID. It returns found_off 0 and prev_off equal to the offset of the last header, or 0 and 0 for an empty chain.
- R5: Before following a nonzero next field, the walker checks its value. The value must be 4-byte aligned and must lie within 0x100..0xFF8 inclusive; 0xFF8 itself is valid. Any violation ends the operation with err high, found_off 0 and prev_off 0.
- R6: A walk that would visit more than VISIT_LIMIT headers (default 1024) ends with err high instead of continuing. For example, a header at 0x100 that points to itself raises err after exactly 1024 visits.
- R7: Append (op code 2) with new_off other than 0x100 walks to the tail. It then writes the tail word back with bits 31:20 replaced by new_off and bits 19:0 unchanged. Next it writes {12'h000, new_ver, cap_id} at new_off. It finishes with found_off = new_off and prev_off = tail offset, and performs exactly two writes.
- R8: Append with new_off equal to 0x100 performs no read and exactly one write, {12'h000, new_ver, cap_id} at 0x100. Done follows one cycle after acceptance, with found_off 0x100 and prev_off 0.
- R9: Append is rejected with err high, no memory write and done on the cycle after acceptance in any of these cases: new_off has nonzero low two bits; new_off is below 0x100; new_size is below 8; or new_off + new_size exceeds 0x1000. An append with new_off other than 0x100 onto an empty chain also ends with err high and no write.
- R10: busy rises on the cycle after an accepted start. done is a one-cycle pulse issued 2·n cycles after acceptance for a walk that visits n headers. A start pulsed while busy is ignored.
- R11: During and after reset, busy, done, err, mem_en, mem_we, found_off and prev_off are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch an operation (accepted when busy is low) |
| op | input | 2 | 0 lookup, 1 tail search, 2 append, 3 lookup |
| cap_id | input | 16 | ID to search for, or ID of the appended header |
| new_ver | input | 4 | Version of the appended header |
| new_off | input | 12 | Byte offset of the appended header |
| new_size | input | 13 | Byte length of the appended capability |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last operation ended on an error |
| found_off | output | 12 | Matched or appended header offset, else 0 |
| prev_off | output | 12 | Preceding or tail header offset, else 0 |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 10 | Memory word address (byte offset / 4) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The assertions assume the memory returns the addressed word exactly one cycle after a read request. They also assume that nothing else modifies the chain while busy is high, so that a header read in one cycle is still the one being decoded in the next. The stimulus honours this by modelling the RAM with a fixed one-cycle read latency and by rebuilding chains only between operations. Start is pulsed for one cycle, except in the single test that deliberately pulses it during a walk.

// File: rtl/xcw_pkg.sv
package xcw_pkg;
  localparam int ID_W  = 16;
  localparam int VER_W = 4;
  localparam int NXT_W = 12;
  localparam int HDR_W = ID_W + VER_W + NXT_W;
  localparam int LOW_W = ID_W + VER_W;

  localparam logic [NXT_W-1:0] CHAIN_BASE = 12'h100;
  localparam logic [NXT_W-1:0] CHAIN_LAST = 12'hFF8;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_TAIL   = 2'd1,
    OP_APPEND = 2'd2,
    OP_LOOKUP2 = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    EV_EMPTY,
    EV_MATCH,
    EV_TAIL,
    EV_BADPTR,
    EV_FOLLOW
  } ev_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_CMP,
    S_WTAIL,
    S_WNEW,
    S_DONE
  } st_e;

  typedef struct packed {
    logic [NXT_W-1:0] nxt;
    logic [VER_W-1:0] ver;
    logic [ID_W-1:0]  id;
  } hdr_t;
endpackage

// File: rtl/xcw_hdr_eval.sv
module xcw_hdr_eval
  import xcw_pkg::*;
(
  input  hdr_t            hdr,
  input  logic            at_base,
  input  logic            match_en,
  input  logic [ID_W-1:0] want_id,
  output ev_e             ev
);
  logic bad_ptr;

  always_comb begin
    bad_ptr = (hdr.nxt[1:0] != 2'b00) || (hdr.nxt < CHAIN_BASE) || (hdr.nxt > CHAIN_LAST);
    if (at_base && (hdr == '0))               ev = EV_EMPTY;
    else if (match_en && (hdr.id == want_id)) ev = EV_MATCH;
    else if (hdr.nxt == '0)                   ev = EV_TAIL;
    else if (bad_ptr)                         ev = EV_BADPTR;
    else                                      ev = EV_FOLLOW;
  end
endmodule

// File: rtl/xcw_visit_ctr.sv
module xcw_visit_ctr #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/xcw_append_chk.sv
module xcw_append_chk
  import xcw_pkg::*;
#(
  parameter int MIN_BYTES = 8
) (
  input  logic [NXT_W-1:0] off,
  input  logic [NXT_W:0]   size,
  output logic             ok
);
  localparam int SUM_W = NXT_W + 2;
  localparam logic [SUM_W-1:0] SPAN = SUM_W'(1 << NXT_W);
  logic [SUM_W-1:0] end_off;

  always_comb begin
    end_off = SUM_W'(off) + SUM_W'(size);
    ok = (off[1:0] == 2'b00) && (off >= CHAIN_BASE) &&
         (size >= (NXT_W+1)'(MIN_BYTES)) && (end_off <= SPAN);
  end
endmodule

// File: rtl/xcw_walker.sv
module xcw_walker
  import xcw_pkg::*;
#(
  parameter int VISIT_LIMIT = 1024,
  parameter int MIN_BYTES   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [15:0]       cap_id,
  input  logic [3:0]        new_ver,
  input  logic [11:0]       new_off,
  input  logic [12:0]       new_size,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [11:0]       found_off,
  output logic [11:0]       prev_off,
  output logic              mem_en,
  output logic              mem_we,
  output logic [9:0]        mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int WORD_AW = NXT_W - 2;

  st_e              st;
  op_e              op_q;
  logic [ID_W-1:0]  id_q;
  logic [VER_W-1:0] ver_q;
  logic [NXT_W-1:0] noff_q, cur_q, prev_q, found_q, prevo_q;
  logic [LOW_W-1:0] tail_q;
  logic             err_q;

  hdr_t hdr;
  ev_e  ev;
  logic app_ok, at_limit, is_app, match_en, accept;

  assign hdr      = hdr_t'(mem_rdata);
  assign is_app   = (op_q == OP_APPEND);
  assign match_en = (op_q == OP_LOOKUP) || (op_q == OP_LOOKUP2);
  assign accept   = (st == S_IDLE) && start;

  xcw_hdr_eval u_eval (
    .hdr      (hdr),
    .at_base  (cur_q == CHAIN_BASE),
    .match_en (match_en),
    .want_id  (id_q),
    .ev       (ev)
  );

  xcw_visit_ctr #(.LIMIT(VISIT_LIMIT)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .inc      ((st == S_CMP) && (ev == EV_FOLLOW)),
    .at_limit (at_limit)
  );

  xcw_append_chk #(.MIN_BYTES(MIN_BYTES)) u_app (
    .off  (new_off),
    .size (new_size),
    .ok   (app_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      op_q    <= OP_LOOKUP;
      id_q    <= '0;
      ver_q   <= '0;
      noff_q  <= '0;
      cur_q   <= '0;
      prev_q  <= '0;
      found_q <= '0;
      prevo_q <= '0;
      tail_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q    <= op_e'(op);
          id_q    <= cap_id;
          ver_q   <= new_ver;
          noff_q  <= new_off;
          cur_q   <= CHAIN_BASE;
          prev_q  <= '0;
          found_q <= '0;
          prevo_q <= '0;
          err_q   <= 1'b0;
          if (op_e'(op) == OP_APPEND && !app_ok) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else if (op_e'(op) == OP_APPEND && new_off == CHAIN_BASE) begin
            found_q <= new_off;
            st      <= S_WNEW;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: st <= S_CMP;
        S_CMP: begin
          case (ev)
            EV_EMPTY: begin
              err_q <= is_app;
              st    <= S_DONE;
            end
            EV_MATCH: begin
              found_q <= cur_q;
              prevo_q <= prev_q;
              st      <= S_DONE;
            end
            EV_TAIL: begin
              prevo_q <= cur_q;
              if (is_app) begin
                tail_q  <= mem_rdata[LOW_W-1:0];
                found_q <= noff_q;
                st      <= S_WTAIL;
              end else begin
                st <= S_DONE;
              end
            end
            EV_BADPTR: begin
              err_q <= 1'b1;
              st    <= S_DONE;
            end
            default: begin
              if (at_limit) begin
                err_q <= 1'b1;
                st    <= S_DONE;
              end else begin
                prev_q <= cur_q;
                cur_q  <= hdr.nxt;
                st     <= S_RD;
              end
            end
          endcase
        end
        S_WTAIL: st <= S_WNEW;
        S_WNEW:  st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q[NXT_W-1:2];
    mem_wdata = '0;
    case (st)
      S_RD: mem_en = 1'b1;
      S_WTAIL: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = {noff_q, tail_q};
      end
      S_WNEW: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = noff_q[NXT_W-1:2];
        mem_wdata = {{NXT_W{1'b0}}, ver_q, id_q};
      end
      default: ;
    endcase
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign err       = err_q;
  assign found_off = found_q;
  assign prev_off  = prevo_q;

  logic unused_aw;
  assign unused_aw = (WORD_AW == 10);
endmodule

// File: rtl/xcw_walker_chk.sv
module xcw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic [11:0] found_off,
  input logic [11:0] prev_off,
  input logic        mem_en,
  input logic        mem_we,
  input logic [9:0]  mem_addr
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R10

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en); // R11

  AST_ADDR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (mem_addr >= 10'd64)); // R5

  AST_FOUND_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found_off[1:0] == 2'b00)); // R1

  AST_ERR_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (found_off == 12'h0 && prev_off == 12'h0)); // R5

  AST_WRITE_IN_OP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (busy && !done && mem_en)); // R7
endmodule

bind xcw_walker xcw_walker_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .found_off (found_off),
  .prev_off  (prev_off),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/sim_xcw_walker.sv
module sim_xcw_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_MAX   = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [15:0] cap_id = '0;
  logic [3:0] new_ver = '0;
  logic [11:0] new_off = '0;
  logic [12:0] new_size = '0;
  logic busy, done, err, mem_en, mem_we;
  logic [11:0] found_off, prev_off;
  logic [9:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:1023];
  int nchk = 0, nfail = 0, wr_cnt = 0;
  int offs [0:7];
  logic [15:0] idv [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  xcw_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cap_id(cap_id),
    .new_ver(new_ver), .new_off(new_off), .new_size(new_size),
    .busy(busy), .done(done), .err(err), .found_off(found_off),
    .prev_off(prev_off), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = '0;
  endtask

  task automatic build(input int n, input int step, input bit desc);
    clear_mem();
    for (int k = 0; k < n; k++) begin
      if (k == 0)    offs[k] = 'h100;
      else if (desc) offs[k] = 'hFF8 - (k - 1) * step;
      else           offs[k] = 'h100 + k * step;
      idv[k] = 16'hA000 + 16'(k * 'h0101) + 16'(step);
    end
    for (int k = 0; k < n; k++)
      mem[offs[k] >> 2] = {(k == n - 1) ? 12'h000 : 12'(offs[k+1]), 4'(k), idv[k]};
  endtask

  task automatic run(input logic [1:0] o, input logic [15:0] id, input logic [3:0] v,
                     input logic [11:0] noff, input logic [12:0] sz, output int cyc);
    @(negedge clk);
    op = o; cap_id = id; new_ver = v; new_off = noff; new_size = sz; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < WAIT_MAX) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL R10 watchdog actual=busy expected=done");
    end
  endtask

  initial begin
    int cyc, w0;
    logic [31:0] old;
    int bad_list [0:2];
    bad_list[0] = 'h102; bad_list[1] = 'h080; bad_list[2] = 'hFFC;
    clear_mem();
    repeat (3) @(negedge clk);
    check("R11 busy", busy, 0); check("R11 done", done, 0); check("R11 err", err, 0);
    check("R11 mem_en", mem_en, 0); check("R11 mem_we", mem_we, 0);
    check("R11 found", found_off, 0); check("R11 prev", prev_off, 0);
    rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int n = 1; n <= 6; n++) begin
          int step;
          step = (s == 0) ? 'h8 : 'h100;
          build(n, step, d[0]);
          for (int k = 0; k < n; k++) begin
            run(2'd0, idv[k], 0, 0, 0, cyc);
            check("R1 found", found_off, offs[k]);
            check("R1 prev", prev_off, (k == 0) ? 0 : offs[k-1]);
            check("R1 err", err, 0);
            check("R10 latency", cyc, 2 * (k + 1));
          end
          run(2'd0, 16'h1234, 0, 0, 0, cyc);
          check("R2 found", found_off, 0);
          check("R2 prev", prev_off, offs[n-1]);
          check("R2 err", err, 0);
          check("R10 latency miss", cyc, 2 * n);
          run(2'd1, idv[0], 0, 0, 0, cyc);
          check("R4 found", found_off, 0);
          check("R4 prev", prev_off, offs[n-1]);
          run(2'd3, idv[n-1], 0, 0, 0, cyc);
          check("R1 op3 found", found_off, offs[n-1]);
        end
      end
    end

    clear_mem();
    run(2'd0, 16'h0000, 0, 0, 0, cyc);
    check("R3 found", found_off, 0); check("R3 prev", prev_off, 0);
    check("R3 err", err, 0); check("R3 latency", cyc, 2);
    run(2'd1, 16'h0, 0, 0, 0, cyc);
    check("R4 empty found", found_off, 0); check("R4 empty prev", prev_off, 0);

    for (int b = 0; b < 3; b++) begin
      clear_mem();
      mem['h40] = {12'(bad_list[b]), 4'h1, 16'hA000};
      run(2'd0, 16'h1234, 0, 0, 0, cyc);
      check("R5 err", err, 1); check("R5 found", found_off, 0); check("R5 prev", prev_off, 0);
    end
    clear_mem();
    mem['h40] = {12'hFF8, 4'h1, 16'hA000};
    mem['hFF8 >> 2] = {12'h000, 4'h2, 16'hB000};
    run(2'd0, 16'hB000, 0, 0, 0, cyc);
    check("R5 edge found", found_off, 'hFF8); check("R5 edge prev", prev_off, 'h100);
    check("R5 edge err", err, 0);

    clear_mem();
    mem['h40] = {12'h100, 4'h1, 16'hA000};
    run(2'd0, 16'h1234, 0, 0, 0, cyc);
    check("R6 err", err, 1); check("R6 latency", cyc, 2 * 1024);

    for (int n = 1; n <= 4; n++) begin
      build(n, 'h100, 1'b0);
      old = mem[offs[n-1] >> 2];
      w0 = wr_cnt;
      run(2'd2, 16'h7E00 + 16'(n), 4'(n), 12'hE00, 13'd16, cyc);
      check("R7 err", err, 0); check("R7 found", found_off, 'hE00);
      check("R7 prev", prev_off, offs[n-1]); check("R7 writes", wr_cnt - w0, 2);
      check("R7 tail", mem[offs[n-1] >> 2], {12'hE00, old[19:0]});
      check("R7 new", mem['hE00 >> 2], {12'h000, 4'(n), 16'h7E00 + 16'(n)});
      run(2'd0, 16'h7E00 + 16'(n), 0, 0, 0, cyc);
      check("R7 relook found", found_off, 'hE00); check("R7 relook prev", prev_off, offs[n-1]);
    end

    clear_mem();
    w0 = wr_cnt;
    run(2'd2, 16'h5555, 4'h2, 12'h100, 13'd8, cyc);
    check("R8 err", err, 0); check("R8 found", found_off, 'h100); check("R8 prev", prev_off, 0);
    check("R8 writes", wr_cnt - w0, 1); check("R8 latency", cyc, 1);
    check("R8 word", mem['h40], {12'h000, 4'h2, 16'h5555});

    build(2, 'h100, 1'b0);
    for (int c = 0; c < 4; c++) begin
      logic [11:0] o2; logic [12:0] z2;
      o2 = (c == 0) ? 12'h102 : (c == 1) ? 12'h0FC : (c == 2) ? 12'h800 : 12'hFF8;
      z2 = (c == 2) ? 13'd4 : 13'd16;
      w0 = wr_cnt;
      run(2'd2, 16'h6666, 4'h1, o2, z2, cyc);
      check("R9 err", err, 1); check("R9 writes", wr_cnt - w0, 0);
      check("R9 found", found_off, 0); check("R9 latency", cyc, 0);
    end
    w0 = wr_cnt;
    run(2'd2, 16'h6666, 4'h1, 12'hFF8, 13'd8, cyc);
    check("R9 edge err", err, 0); check("R9 edge found", found_off, 'hFF8);
    check("R9 edge writes", wr_cnt - w0, 2);
    clear_mem();
    w0 = wr_cnt;
    run(2'd2, 16'h6666, 4'h1, 12'h200, 13'd16, cyc);
    check("R9 empty err", err, 1); check("R9 empty writes", wr_cnt - w0, 0);

    build(4, 'h8, 1'b0);
    @(negedge clk);
    op = 2'd0; cap_id = idv[3]; start = 1'b1;
    @(negedge clk);
    check("R10 busy", busy, 1);
    op = 2'd1; cap_id = idv[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < WAIT_MAX) begin
      @(negedge clk);
      cyc++;
    end
    check("R10 ignore found", found_off, offs[3]);
    check("R10 ignore prev", prev_off, offs[2]);
    check("R10 ignore latency", cyc, 8);
    @(negedge clk);
    check("R10 pulse", done, 0);
    check("R10 idle", busy, 0);

    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule